// File: doc/BRIEF.md
# Programmable Ramp Sweeper with Limit Dwell Control

The block sweeps a modulation word back and forth between a lower and an upper bound held on its inputs. It is meant to feed a signal synthesizer. The up and down moves each have their own step size and their own step interval in clock ticks. A step lands only when an interval countdown runs out. A step that would reach or cross a bound stops exactly on that bound, and a flag for that bound rises for a single clock.

An external direction input picks the sweep direction. When that input changes level, the sweep reverses from wherever it currently stands. Two dwell-disable bits decide what happens at each bound:
- With neither bit set, the sweep holds at the bound.
- With only the low bit set, the sweep jumps from the lower bound back to the upper bound.
- With only the high bit set, the sweep jumps from the upper bound back to the lower bound.
- With both bits set, the sweep turns around by itself at each bound and forms a triangle. Unequal step sizes make the triangle lopsided, down to a sawtooth.

A destination selector sends the sweep to one of three synthesizer parameters: frequency, phase or amplitude. A synchronous clear restarts the sweep at the lower bound, moving up.

Top module: `ramp_sweeper`

## Requirements
- R1: After reset, `ramp_val` is 0, `dir_up` is 1, and both limit flags are 0. A cycle with `clr` high loads `lo_lim` into `ramp_val`, sets `dir_up` to 1 and clears both flags at the next edge.
- R2: Steps are paced by a countdown. When the interval of the current direction is N, a moving sweep changes at most once every N+1 clocks. Moving up uses `up_itv` and moving down uses `dn_itv`. The countdown reloads on clear, on a change of the direction pin, and after each expiry. After reset it is already expired.
- R3: An up step adds `up_step` and a down step subtracts `dn_step`. The two sizes are independent.
- R4: An up step whose sum would equal or exceed `hi_lim` puts exactly `hi_lim` on `ramp_val` and pulses `at_hi`. A down step whose result would equal or fall below `lo_lim`, including a borrow below zero, puts exactly `lo_lim` on `ramp_val` and pulses `at_lo`.
- R5: With `free_lo` = 0 and `free_hi` = 0, a sweep sitting on a bound in the direction of that bound holds its value on every further expiry.
- R6: With `free_lo` set, an expiry while moving down with `ramp_val` equal to `lo_lim` reloads `ramp_val` to `hi_lim`.
- R7: With `free_hi` set, an expiry while moving up with `ramp_val` equal to `hi_lim` reloads `ramp_val` to `lo_lim`.
- R8: With both `free_lo` and `free_hi` set, a clamp to a bound also reverses `dir_up` in the same edge, so the sweep forms a triangle with no pin activity.
- R9: A level change of `dir_pin` from its value in the previous clock sets `dir_up` to the new pin level. In that clock, `ramp_val` does not move.
- R10: The `dest_sel` encoding is 0 for frequency, 1 for phase, 2 for amplitude and 3 for none. `dest_hot` bit k is high only for selection k. The selected word carries `ramp_val`: the full word for frequency, its top PH_W bits for phase, and its top AMP_W bits for amplitude. The words that are not selected are 0.
- R11: `at_hi` and `at_lo` are never high together, and neither stays high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous sweep restart at the lower bound |
| lo_lim | input | VAL_W | Lower sweep bound |
| hi_lim | input | VAL_W | Upper sweep bound |
| up_step | input | VAL_W | Increment per up step |
| dn_step | input | VAL_W | Decrement per down step |
| up_itv | input | ITV_W | Extra clocks between up steps |
| dn_itv | input | ITV_W | Extra clocks between down steps |
| free_lo | input | 1 | Disable holding at the lower bound |
| free_hi | input | 1 | Disable holding at the upper bound |
| dir_pin | input | 1 | External direction level, 1 = up |
| dest_sel | input | 2 | Destination parameter select |
| ramp_val | output | VAL_W | Current sweep value |
| dir_up | output | 1 | Current direction, 1 = up |
| at_hi | output | 1 | One-clock pulse on clamping to the upper bound |
| at_lo | output | 1 | One-clock pulse on clamping to the lower bound |
| freq_word | output | VAL_W | Frequency modulation word |
| phase_word | output | PH_W | Phase modulation word |
| amp_word | output | AMP_W | Amplitude modulation word |
| dest_hot | output | 3 | One-hot destination indication |

## Verification
The hardest cases to reach from the ports involve coincidences. One is a direction-pin change landing in the same clock as a countdown expiry. Another is a step that lands exactly on a bound, as opposed to overshooting it or borrowing below zero. A third is a reload that happens while the pin is pushing into a bound. Directed phases set small spans and short intervals so that exact landings and every dwell mode recur within a few dozen clocks. Seeded random phases draw bounds over the full word, with occasional huge or zero steps and pin toggles about one clock in eight. Across those phases, the coincidences with expiry and with reloads come up many times, and every clock is compared against a reference model in the bench.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    typedef enum logic [1:0] {
        DEST_FREQ  = 2'd0,
        DEST_PHASE = 2'd1,
        DEST_AMP   = 2'd2,
        DEST_NONE  = 2'd3
    } dest_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_STEP,
        ACT_CLAMP,
        ACT_RELOAD,
        ACT_HOLD
    } act_e;

    typedef struct packed {
        logic lo_free;
        logic hi_free;
    } dwell_t;

    typedef struct packed {
        act_e act;
        logic flip;
        logic hit_hi;
        logic hit_lo;
    } step_ctl_t;

    localparam int NUM_DEST = 3;

    function automatic logic bounce_mode(dwell_t d);
        return d.lo_free & d.hi_free;
    endfunction

endpackage

// File: rtl/ramp_pacer.sv
module ramp_pacer #(
    parameter int ITV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [ITV_W-1:0] load_val,
    output logic             tick
);
    logic [ITV_W-1:0] cnt;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (reload || tick) begin
            cnt <= load_val;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R2: countdown reloads with the interval of the coming direction
    a_r2_reload_value: assert property (@(posedge clk) disable iff (rst)
        (reload || tick) |=> (cnt == $past(load_val)));

    // R2: between reloads the countdown falls by one each clock
    a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
        (!reload && !tick) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper
    import ramp_pkg::*;
#(
    parameter int VAL_W = 32
) (
    input  logic [VAL_W-1:0] val,
    input  logic             going_up,
    input  logic [VAL_W-1:0] lo_lim,
    input  logic [VAL_W-1:0] hi_lim,
    input  logic [VAL_W-1:0] up_step,
    input  logic [VAL_W-1:0] dn_step,
    input  dwell_t           dwell,
    output logic [VAL_W-1:0] nxt_val,
    output step_ctl_t        ctl
);
    localparam int EXT_W = VAL_W + 1;

    logic [EXT_W-1:0] up_sum;
    logic [EXT_W-1:0] lo_reach;

    assign up_sum   = {1'b0, val} + {1'b0, up_step};
    assign lo_reach = {1'b0, lo_lim} + {1'b0, dn_step};

    always_comb begin
        ctl     = '0;
        ctl.act = ACT_IDLE;
        nxt_val = val;
        if (going_up) begin
            if (val == hi_lim) begin
                if (dwell.hi_free) begin
                    nxt_val = lo_lim;
                    ctl.act = ACT_RELOAD;
                end else begin
                    ctl.act = ACT_HOLD;
                end
            end else if (up_sum >= {1'b0, hi_lim}) begin
                nxt_val    = hi_lim;
                ctl.act    = ACT_CLAMP;
                ctl.hit_hi = 1'b1;
                ctl.flip   = bounce_mode(dwell);
            end else begin
                nxt_val = up_sum[VAL_W-1:0];
                ctl.act = ACT_STEP;
            end
        end else begin
            if (val == lo_lim) begin
                if (dwell.lo_free) begin
                    nxt_val = hi_lim;
                    ctl.act = ACT_RELOAD;
                end else begin
                    ctl.act = ACT_HOLD;
                end
            end else if ({1'b0, val} <= lo_reach) begin
                nxt_val    = lo_lim;
                ctl.act    = ACT_CLAMP;
                ctl.hit_lo = 1'b1;
                ctl.flip   = bounce_mode(dwell);
            end else begin
                nxt_val = val - dn_step;
                ctl.act = ACT_STEP;
            end
        end
    end

endmodule

// File: rtl/ramp_router.sv
module ramp_router
    import ramp_pkg::*;
#(
    parameter int VAL_W = 32,
    parameter int PH_W  = 16,
    parameter int AMP_W = 14
) (
    input  logic [VAL_W-1:0]    val,
    input  dest_e               dest,
    output logic [VAL_W-1:0]    freq_word,
    output logic [PH_W-1:0]     phase_word,
    output logic [AMP_W-1:0]    amp_word,
    output logic [NUM_DEST-1:0] hot
);
    for (genvar k = 0; k < NUM_DEST; k++) begin : g_hot
        assign hot[k] = (dest == dest_e'(k));
    end

    assign freq_word  = hot[DEST_FREQ]  ? val : '0;
    assign phase_word = hot[DEST_PHASE] ? val[VAL_W-1 -: PH_W] : '0;
    assign amp_word   = hot[DEST_AMP]   ? val[VAL_W-1 -: AMP_W] : '0;

endmodule

// File: rtl/ramp_sweeper.sv
module ramp_sweeper
    import ramp_pkg::*;
#(
    parameter int VAL_W = 32,
    parameter int ITV_W = 16,
    parameter int PH_W  = 16,
    parameter int AMP_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [VAL_W-1:0] lo_lim,
    input  logic [VAL_W-1:0] hi_lim,
    input  logic [VAL_W-1:0] up_step,
    input  logic [VAL_W-1:0] dn_step,
    input  logic [ITV_W-1:0] up_itv,
    input  logic [ITV_W-1:0] dn_itv,
    input  logic             free_lo,
    input  logic             free_hi,
    input  logic             dir_pin,
    input  logic [1:0]       dest_sel,
    output logic [VAL_W-1:0] ramp_val,
    output logic             dir_up,
    output logic             at_hi,
    output logic             at_lo,
    output logic [VAL_W-1:0] freq_word,
    output logic [PH_W-1:0]  phase_word,
    output logic [AMP_W-1:0] amp_word,
    output logic [2:0]       dest_hot
);
    logic             pin_q;
    logic             pin_edge;
    logic             tick;
    logic             next_dir;
    logic [VAL_W-1:0] nxt_val;
    step_ctl_t        ctl;
    dwell_t           dwell;

    assign dwell    = '{lo_free: free_lo, hi_free: free_hi};
    assign pin_edge = (dir_pin != pin_q);

    always_comb begin
        if (clr) begin
            next_dir = 1'b1;
        end else if (pin_edge) begin
            next_dir = dir_pin;
        end else if (tick && ctl.flip) begin
            next_dir = ~dir_up;
        end else begin
            next_dir = dir_up;
        end
    end

    ramp_pacer #(.ITV_W(ITV_W)) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .reload   (clr | pin_edge),
        .load_val (next_dir ? up_itv : dn_itv),
        .tick     (tick)
    );

    ramp_stepper #(.VAL_W(VAL_W)) u_stepper (
        .val      (ramp_val),
        .going_up (dir_up),
        .lo_lim   (lo_lim),
        .hi_lim   (hi_lim),
        .up_step  (up_step),
        .dn_step  (dn_step),
        .dwell    (dwell),
        .nxt_val  (nxt_val),
        .ctl      (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_val <= '0;
            dir_up   <= 1'b1;
            pin_q    <= dir_pin;
            at_hi    <= 1'b0;
            at_lo    <= 1'b0;
        end else begin
            pin_q <= dir_pin;
            at_hi <= 1'b0;
            at_lo <= 1'b0;
            if (clr) begin
                ramp_val <= lo_lim;
            end else if (!pin_edge && tick) begin
                ramp_val <= nxt_val;
                at_hi    <= ctl.hit_hi;
                at_lo    <= ctl.hit_lo;
            end
            dir_up <= next_dir;
        end
    end

    ramp_router #(.VAL_W(VAL_W), .PH_W(PH_W), .AMP_W(AMP_W)) u_router (
        .val        (ramp_val),
        .dest       (dest_e'(dest_sel)),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .amp_word   (amp_word),
        .hot        (dest_hot)
    );

    // R1: clear restarts at the lower bound going up
    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ramp_val == $past(lo_lim)) && dir_up && !at_hi && !at_lo);

    // R2: no countdown expiry means no movement
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr && !pin_edge) |=> $stable(ramp_val));

    // R4: the upper flag marks the exact upper bound
    a_r4_hi_exact: assert property (@(posedge clk) disable iff (rst)
        at_hi |-> (ramp_val == $past(hi_lim)));

    // R4: the lower flag marks the exact lower bound
    a_r4_lo_exact: assert property (@(posedge clk) disable iff (rst)
        at_lo |-> (ramp_val == $past(lo_lim)));

    // R5: a dwell decision leaves the value alone
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && !pin_edge && ctl.act == ACT_HOLD) |=> $stable(ramp_val));

    // R9: a pin change sets direction and freezes the value for that clock
    a_r9_pin_follow: assert property (@(posedge clk) disable iff (rst)
        (!clr && pin_edge) |=> (dir_up == $past(dir_pin)) && $stable(ramp_val));

    // R11: the two flags never coincide
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(at_hi && at_lo));

    // R11: each flag lasts one clock
    a_r11_hi_pulse: assert property (@(posedge clk) disable iff (rst)
        at_hi |=> !at_hi);

    a_r11_lo_pulse: assert property (@(posedge clk) disable iff (rst)
        at_lo |=> !at_lo);

endmodule

// File: tb/tb_ramp_sweeper.sv
module tb_ramp_sweeper;
    localparam int  VW = 32;
    localparam int  IW = 16;
    localparam int  PW = 16;
    localparam int  AW = 14;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic [VW-1:0] lo_lim = '0, hi_lim = '0, up_step = '0, dn_step = '0;
    logic [IW-1:0] up_itv = '0, dn_itv = '0;
    logic          free_lo = 1'b0, free_hi = 1'b0, dir_pin = 1'b1;
    logic [1:0]    dest_sel = 2'd0;
    logic [VW-1:0] ramp_val, freq_word;
    logic          dir_up, at_hi, at_lo;
    logic [PW-1:0] phase_word;
    logic [AW-1:0] amp_word;
    logic [2:0]    dest_hot;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    ramp_sweeper #(.VAL_W(VW), .ITV_W(IW), .PH_W(PW), .AMP_W(AW)) dut (
        .clk(clk), .rst(rst), .clr(clr), .lo_lim(lo_lim), .hi_lim(hi_lim),
        .up_step(up_step), .dn_step(dn_step), .up_itv(up_itv), .dn_itv(dn_itv),
        .free_lo(free_lo), .free_hi(free_hi), .dir_pin(dir_pin), .dest_sel(dest_sel),
        .ramp_val(ramp_val), .dir_up(dir_up), .at_hi(at_hi), .at_lo(at_lo),
        .freq_word(freq_word), .phase_word(phase_word), .amp_word(amp_word),
        .dest_hot(dest_hot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    longint unsigned m_val;
    bit              m_dir, m_pinq, m_hi, m_lo;
    longint unsigned m_cnt;

    function automatic longint unsigned itv_of(bit d);
        return d ? longint'(up_itv) : longint'(dn_itv);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_val = 0; m_dir = 1; m_pinq = dir_pin; m_cnt = 0; m_hi = 0; m_lo = 0;
        end else begin
            bit tick;
            bit nd;
            tick = (m_cnt == 0);
            m_hi = 0; m_lo = 0;
            if (clr) begin
                m_val = lo_lim; m_dir = 1; m_cnt = up_itv;
            end else if (dir_pin != m_pinq) begin
                m_dir = dir_pin; m_cnt = itv_of(dir_pin);
            end else begin
                nd = m_dir;
                if (tick) begin
                    if (m_dir) begin
                        if (m_val == hi_lim) begin
                            if (free_hi) m_val = lo_lim;
                        end else if (m_val + up_step >= hi_lim) begin
                            m_val = hi_lim; m_hi = 1;
                            if (free_lo && free_hi) nd = 0;
                        end else m_val = m_val + up_step;
                    end else begin
                        if (m_val == lo_lim) begin
                            if (free_lo) m_val = hi_lim;
                        end else if (m_val <= longint'(lo_lim) + dn_step) begin
                            m_val = lo_lim; m_lo = 1;
                            if (free_lo && free_hi) nd = 1;
                        end else m_val = m_val - dn_step;
                    end
                    m_cnt = itv_of(nd);
                end else begin
                    m_cnt = m_cnt - 1;
                end
                m_dir = nd;
            end
            m_pinq = dir_pin;
        end
    end

    task automatic chk(string tag, bit ok, longint unsigned act, longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output against the model at the falling edge
    task automatic cyc(string tag);
        longint unsigned e_fw, e_pw, e_aw, e_hot;
        @(negedge clk);
        e_fw  = (dest_sel == 2'd0) ? m_val : 0;
        e_pw  = (dest_sel == 2'd1) ? (m_val >> (VW-PW)) : 0;
        e_aw  = (dest_sel == 2'd2) ? (m_val >> (VW-AW)) : 0;
        e_hot = (dest_sel == 2'd3) ? 0 : (1 << dest_sel);
        chk(tag, ramp_val == m_val[VW-1:0], ramp_val, m_val);
        chk(tag, dir_up == m_dir, dir_up, m_dir);
        chk("R11 flags", {at_hi, at_lo} == {m_hi, m_lo}, {at_hi, at_lo}, {m_hi, m_lo});
        chk("R10 route", freq_word == e_fw[VW-1:0] && phase_word == e_pw[PW-1:0] &&
            amp_word == e_aw[AW-1:0] && dest_hot == e_hot[2:0],
            {dest_hot, freq_word}, {e_hot[2:0], e_fw[VW-1:0]});
    endtask

    task automatic run(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic restart(string tag);
        clr = 1'b1;
        cyc(tag);
        clr = 1'b0;
        chk("R1 clear value", ramp_val == lo_lim, ramp_val, lo_lim);
        chk("R1 clear dir", dir_up == 1'b1, dir_up, 1);
    endtask

    task automatic setup(logic [VW-1:0] lo, logic [VW-1:0] hi, logic [VW-1:0] us,
                         logic [VW-1:0] ds, logic [IW-1:0] ui, logic [IW-1:0] di,
                         bit fl, bit fh);
        lo_lim = lo; hi_lim = hi; up_step = us; dn_step = ds;
        up_itv = ui; dn_itv = di; free_lo = fl; free_hi = fh;
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc("R1 reset");
        chk("R1 reset value", ramp_val == 0, ramp_val, 0);

        // R2 and R5: hold at each bound, unequal intervals
        setup(100, 200, 30, 7, 2, 0, 0, 0);
        dir_pin = 1'b1;
        restart("R2");
        run("R2", 20);
        chk("R5 hold high", ramp_val == 200, ramp_val, 200);
        dir_pin = 1'b0;
        run("R5", 25);
        chk("R5 hold low", ramp_val == 100, ramp_val, 100);

        // R4: exact landing and overshoot, R3 step sizes
        setup(0, 12, 4, 5, 0, 0, 0, 0);
        dir_pin = 1'b1;
        restart("R4");
        run("R3", 4);
        dir_pin = 1'b0;
        run("R4", 6);

        // R6: lower dwell disabled, sweep reloads high
        setup(1000, 1100, 10, 30, 0, 1, 1, 0);
        dir_pin = 1'b1;
        restart("R6");
        dir_pin = 1'b0;
        run("R6", 40);

        // R7: upper dwell disabled, sweep reloads low
        setup(500, 560, 20, 3, 1, 0, 0, 1);
        dir_pin = 1'b1;
        restart("R7");
        run("R7", 40);

        // R8: both disabled, asymmetric triangle without the pin
        setup(10, 90, 25, 5, 0, 1, 1, 1);
        restart("R8");
        run("R8", 90);

        // R9: pin reversal mid sweep
        setup(0, 32'hFFFF_0000, 32'h100, 32'h80, 1, 2, 0, 0);
        dir_pin = 1'b1;
        restart("R9");
        run("R9", 9);
        dir_pin = 1'b0;
        cyc("R9");
        chk("R9 reversed", dir_up == 1'b0, dir_up, 0);
        run("R9", 7);
        dir_pin = 1'b1;
        run("R9", 6);

        // R10: every destination code
        for (int d = 0; d < 4; d++) begin
            dest_sel = d[1:0];
            run("R10", 3);
        end

        // random phases
        for (int p = 0; p < 24; p++) begin
            logic [VW-1:0] a, b, span;
            a = $urandom; b = $urandom;
            if (a > b) begin logic [VW-1:0] t; t = a; a = b; b = t; end
            span = b - a;
            setup(a, b, $urandom_range(0, 7) == 0 ? $urandom : (span >> 3) + $urandom_range(0, 3),
                  $urandom_range(0, 7) == 0 ? $urandom : (span >> 4) + $urandom_range(0, 3),
                  IW'($urandom_range(0, 3)), IW'($urandom_range(0, 3)),
                  $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
            dest_sel = 2'($urandom_range(0, 3));
            restart("R3 random");
            for (int i = 0; i < 150; i++) begin
                if ($urandom_range(0, 7) == 0) dir_pin = ~dir_pin;
                cyc("R4 random");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule